// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns the address and mode fields of a fetched instruction into the effective address of its operand. It covers eight ways of locating an operand:

- direct memory addressing;
- memory-indirect addressing;
- operand held in a register;
- register-indirect addressing;
- four auto-stepping pointer variants (increment or decrement, applied before or after the pointer is used).

A controller presents one instruction with a one-cycle `start`. The unit answers with a one-cycle `done` pulse. On that pulse `ea` carries the address and `ea_is_reg` says whether the operand is a register rather than a memory location.

Memory-indirect mode needs an extra memory read. The unit holds `mem_req` and `mem_addr` steady until memory returns a word with `mem_valid`, and the low address bits of that word become the effective address. The auto-stepping modes also update the pointer register. The unit drives a single write port to the register file for this, in the same cycle as `done`. A pointer value whose write is still pending is forwarded to the read path, so an instruction that follows at once sees the updated pointer. All pointer arithmetic wraps modulo 2^12.

Top module: `ea_gen_unit`

## Requirements
- R1: While reset is asserted and right after it, `done`, `busy`, `mem_req`, `rf_we` and `ea_is_reg` are 0, and `ea` is 0.
- R2: Mode code 0 (direct) makes `ea` equal to `addr_field`, with `ea_is_reg`=0 and `done` high in the cycle after `start`. It issues no memory request and no register write.
- R3: Mode code 1 (indirect) raises `mem_req`, with `mem_addr`=`addr_field`, from the cycle after `start`. Both are held until `mem_valid`. In the following cycle `done` is high, `mem_req` is low, and `ea` equals bits 11:0 of `mem_rdata`.
- R4: Mode code 2 (register) sets `ea_is_reg`=1 and makes `ea` equal to `reg_sel` zero-extended, with `done` in the cycle after `start`. It does no register write.
- R5: Mode code 3 (register indirect) makes `ea` equal to the content of register `reg_sel`, with `done` in the cycle after `start`. The register is left unchanged.
- R6: Mode codes 4 (post-increment) and 6 (post-decrement) make `ea` equal to the old register value. In the `done` cycle they write the old value plus or minus one back to that register.
- R7: Mode codes 5 (pre-decrement) and 7 (pre-increment) make `ea` equal to the register value minus or plus one. The same value is written back in the `done` cycle.
- R8: Pointer stepping wraps modulo 4096: 0xFFF plus one gives 0x000, and 0x000 minus one gives 0xFFF.
- R9: A `start` received while `busy` is high is ignored. It produces no `done`, no result and no register write.
- R10: An auto-stepping instruction that starts in the `done` cycle of another one on the same register uses the value that the earlier instruction is writing back.
- R11: Each accepted instruction gives exactly one single-cycle `done` pulse. `rf_we` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction present for one cycle |
| mode | input | 3 | Addressing mode code |
| addr_field | input | 12 | Address field of the instruction |
| reg_sel | input | 3 | Register named by the instruction |
| rf_raddr | output | 3 | Register file read address |
| rf_rdata | input | 12 | Register file read data (combinational) |
| rf_we | output | 1 | Pointer writeback enable |
| rf_waddr | output | 3 | Pointer writeback register |
| rf_wdata | output | 12 | Pointer writeback value |
| mem_req | output | 1 | Pointer read request to memory |
| mem_addr | output | 12 | Pointer read address |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | 16 | Memory read data |
| ea | output | 12 | Effective address |
| ea_is_reg | output | 1 | Operand resides in a register |
| done | output | 1 | Result strobe |
| busy | output | 1 | Waiting for an indirect pointer |

## Verification
Different faults surface at different points, and each has a set delay after the event that causes it:

- A wrong mode decode or stepping direction shows up in `ea` at the very next `done`, one cycle after `start`.
- A wrong writeback shows up in the shadow register contents one cycle after that.
- A sequencer stuck in its wait state shows up as `busy` never falling.
- A sequencer that leaves the wait state early shows up as a `done` with a stale or wrong `ea`, or as a `done` the scoreboard did not expect.

A missing forward of the pending pointer only becomes visible when two stepping instructions on the same register run back to back. The second result is then off by one, and the final register value is also off by one.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    M_DIR     = 3'd0,
    M_IND     = 3'd1,
    M_REG     = 3'd2,
    M_RIND    = 3'd3,
    M_POSTINC = 3'd4,
    M_PREDEC  = 3'd5,
    M_POSTDEC = 3'd6,
    M_PREINC  = 3'd7
  } ea_mode_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_WAIT = 1'b1
  } ea_state_e;
endpackage

// File: rtl/ea_ptr_step.sv
module ea_ptr_step
  import ea_pkg::*;
#(
  parameter int AW = 12
) (
  input  ea_mode_e        mode,
  input  logic [AW-1:0]   ptr,
  output logic [AW-1:0]   ptr_ea,
  output logic [AW-1:0]   ptr_nxt,
  output logic            ptr_wr
);
  logic [AW-1:0] plus_one;
  logic [AW-1:0] minus_one;

  // Modulo 2^AW wrap comes from the truncating width.
  assign plus_one  = ptr + AW'(1);
  assign minus_one = ptr - AW'(1);

  always_comb begin
    ptr_ea  = ptr;
    ptr_nxt = ptr;
    ptr_wr  = 1'b0;
    case (mode)
      M_POSTINC: begin ptr_ea = ptr;       ptr_nxt = plus_one;  ptr_wr = 1'b1; end
      M_POSTDEC: begin ptr_ea = ptr;       ptr_nxt = minus_one; ptr_wr = 1'b1; end
      M_PREDEC:  begin ptr_ea = minus_one; ptr_nxt = minus_one; ptr_wr = 1'b1; end
      M_PREINC:  begin ptr_ea = plus_one;  ptr_nxt = plus_one;  ptr_wr = 1'b1; end
      default:   begin ptr_ea = ptr;       ptr_nxt = ptr;       ptr_wr = 1'b0; end
    endcase
  end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  ea_mode_e        mode,
  input  logic [AW-1:0]   addr_field,
  input  logic [RW-1:0]   reg_sel,
  input  logic [AW-1:0]   ptr_ea,
  input  logic [AW-1:0]   ptr_nxt,
  input  logic            ptr_wr,
  input  logic            mem_valid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic            rf_we,
  output logic [RW-1:0]   rf_waddr,
  output logic [AW-1:0]   rf_wdata,
  output logic [AW-1:0]   ea,
  output logic            ea_is_reg,
  output logic            done,
  output logic            busy
);
  ea_state_e     state_q, state_d;
  logic          accept;
  logic          ptr_done;
  logic          done_d;
  logic [AW-1:0] ea_d;
  logic          is_reg_d;
  logic          maddr_en;

  assign accept   = start && (state_q == S_IDLE);
  assign ptr_done = (state_q == S_WAIT) && mem_valid;
  assign maddr_en = accept && (mode == M_IND);

  always_comb begin
    state_d = state_q;
    if (maddr_en)      state_d = S_WAIT;
    else if (ptr_done) state_d = S_IDLE;
  end

  always_comb begin
    done_d   = 1'b0;
    ea_d     = ea;
    is_reg_d = ea_is_reg;
    if (accept && (mode != M_IND)) begin
      done_d   = 1'b1;
      is_reg_d = (mode == M_REG);
      case (mode)
        M_DIR:   ea_d = addr_field;
        M_REG:   ea_d = AW'(reg_sel);
        default: ea_d = ptr_ea;
      endcase
    end else if (ptr_done) begin
      done_d   = 1'b1;
      is_reg_d = 1'b0;
      ea_d     = mem_rdata[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      done      <= 1'b0;
      ea        <= '0;
      ea_is_reg <= 1'b0;
      mem_addr  <= '0;
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      rf_we   <= accept && ptr_wr;
      if (done_d) begin
        ea        <= ea_d;
        ea_is_reg <= is_reg_d;
      end
      if (maddr_en) mem_addr <= addr_field;
      if (accept && ptr_wr) begin
        rf_waddr <= reg_sel;
        rf_wdata <= ptr_nxt;
      end
    end
  end

  assign mem_req = (state_q == S_WAIT);
  assign busy    = (state_q == S_WAIT);

  // R3: request and address stay put until memory answers
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));
  // R3: the answer ends the wait with a result strobe
  a_r3_valid_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_valid |=> done && !mem_req);
  // R11: writeback only alongside the result strobe
  a_r11_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done);
  // R11: a result never coexists with an outstanding pointer read
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
  // R9: a start during the wait creates no writeback
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && start |=> !rf_we);
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
  import ea_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      mode,
  input  logic [AW-1:0]   addr_field,
  input  logic [RW-1:0]   reg_sel,
  output logic [RW-1:0]   rf_raddr,
  input  logic [AW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [RW-1:0]   rf_waddr,
  output logic [AW-1:0]   rf_wdata,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_valid,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   ea,
  output logic            ea_is_reg,
  output logic            done,
  output logic            busy
);
  ea_mode_e      mode_e;
  logic [AW-1:0] ptr;
  logic [AW-1:0] ptr_ea;
  logic [AW-1:0] ptr_nxt;
  logic          ptr_wr;

  assign mode_e   = ea_mode_e'(mode);
  assign rf_raddr = reg_sel;
  // Forward a pointer whose writeback has not landed yet.
  assign ptr = (rf_we && (rf_waddr == reg_sel)) ? rf_wdata : rf_rdata;

  ea_ptr_step #(.AW(AW)) u_step (
    .mode    (mode_e),
    .ptr     (ptr),
    .ptr_ea  (ptr_ea),
    .ptr_nxt (ptr_nxt),
    .ptr_wr  (ptr_wr)
  );

  ea_seq #(.AW(AW), .DW(DW), .RW(RW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode_e),
    .addr_field (addr_field),
    .reg_sel    (reg_sel),
    .ptr_ea     (ptr_ea),
    .ptr_nxt    (ptr_nxt),
    .ptr_wr     (ptr_wr),
    .mem_valid  (mem_valid),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata),
    .ea         (ea),
    .ea_is_reg  (ea_is_reg),
    .done       (done),
    .busy       (busy)
  );
endmodule

// File: tb/sim_ea_gen_unit.sv
`timescale 1ns/1ps
module sim_ea_gen_unit;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NREG = 8;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [2:0] mode;
  logic [AW-1:0] addr_field;
  logic [RW-1:0] reg_sel;
  logic [RW-1:0] rf_raddr;
  logic [AW-1:0] rf_rdata;
  logic rf_we;
  logic [RW-1:0] rf_waddr;
  logic [AW-1:0] rf_wdata;
  logic mem_req;
  logic [AW-1:0] mem_addr;
  logic mem_valid;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] ea;
  logic ea_is_reg;
  logic done;
  logic busy;

  int checks = 0;
  int errors = 0;
  int lat = 1;
  int cnt;

  logic [AW-1:0] rf [NREG];
  logic [AW-1:0] exp_reg [NREG];
  logic [AW:0] sb [$];

  always #2 clk = ~clk;

  ea_gen_unit u0 (.*);

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return {4'hA, a ^ 12'h5A5};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0; mem_rdata <= '0; cnt <= 0;
    end else if (mem_valid) begin
      mem_valid <= 1'b0; cnt <= 0;
    end else if (mem_req) begin
      if (cnt + 1 >= lat) begin
        mem_valid <= 1'b1; mem_rdata <= memf(mem_addr);
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compare every result strobe with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) chk(1'b0, "R11 unexpected done", {ea_is_reg, ea}, 0);
      else begin
        logic [AW:0] e;
        e = sb.pop_front();
        chk({ea_is_reg, ea} == e, "R2-R8 result", {ea_is_reg, ea}, e);
      end
    end
  end

  // Driver: predict, push, stimulate, then check writeback.
  task automatic do_op(input logic [2:0] m, input logic [AW-1:0] a, input logic [RW-1:0] r, input string tag);
    logic [AW-1:0] e;
    logic [AW-1:0] old;
    old = exp_reg[r];
    case (m)
      3'd0: e = a;
      3'd1: e = memf(a) & 12'hFFF;
      3'd2: e = AW'(r);
      3'd3: e = old;
      3'd4: begin e = old; exp_reg[r] = old + 1'b1; end
      3'd6: begin e = old; exp_reg[r] = old - 1'b1; end
      3'd5: begin e = old - 1'b1; exp_reg[r] = e; end
      default: begin e = old + 1'b1; exp_reg[r] = e; end
    endcase
    sb.push_back({(m == 3'd2), e});
    start = 1'b1; mode = m; addr_field = a; reg_sel = r;
    @(negedge clk);
    start = 1'b0;
    if (m == 3'd1) begin
      chk(mem_req && mem_addr == a, {tag, " R3 request"}, mem_addr, a);
      while (busy) @(negedge clk);
    end else begin
      chk(!mem_req, {tag, " R2 no request"}, mem_req, 0);
    end
    chk(done, {tag, " R11 done"}, done, 1);
    chk(rf_we == m[2], {tag, " R11 write enable"}, rf_we, m[2]);
    @(negedge clk);
    chk(!done, {tag, " R11 single pulse"}, done, 0);
    chk(rf[r] == exp_reg[r], {tag, " register value"}, rf[r], exp_reg[r]);
  endtask

  initial begin
    #400000;
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = '0; addr_field = '0; reg_sel = '0;
    rf[0] = 12'h000; rf[1] = 12'hFFF; rf[2] = 12'h234; rf[3] = 12'h800;
    for (int i = 4; i < NREG; i++) rf[i] = AW'(i * 12'h100);
    for (int i = 0; i < NREG; i++) exp_reg[i] = rf[i];
    repeat (3) @(negedge clk);
    chk(!done && !busy && !mem_req && !rf_we && !ea_is_reg && ea == 0, "R1 reset", {done, busy, mem_req, rf_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && ea == 0, "R1 after reset", ea, 0);

    do_op(3'd0, 12'h123, 3'd0, "R2 direct");
    do_op(3'd0, 12'hFFF, 3'd0, "R2 direct max");
    do_op(3'd2, 12'h000, 3'd5, "R4 register");
    do_op(3'd3, 12'h000, 3'd2, "R5 reg indirect");
    do_op(3'd4, 12'h000, 3'd2, "R6 post-inc");
    do_op(3'd6, 12'h000, 3'd3, "R6 post-dec");
    do_op(3'd5, 12'h000, 3'd4, "R7 pre-dec");
    do_op(3'd7, 12'h000, 3'd5, "R7 pre-inc");
    do_op(3'd4, 12'h000, 3'd1, "R8 wrap up");
    do_op(3'd5, 12'h000, 3'd0, "R8 wrap down");
    lat = 1; do_op(3'd1, 12'h0AB, 3'd0, "R3 indirect fast");
    lat = 4; do_op(3'd1, 12'hF00, 3'd0, "R3 indirect slow");

    // R9: starts during the pointer wait are dropped
    lat = 6;
    sb.push_back({1'b0, memf(12'h0F0) & 12'hFFF});
    start = 1'b1; mode = 3'd1; addr_field = 12'h0F0; reg_sel = 3'd0;
    @(negedge clk);
    mode = 3'd4; reg_sel = 3'd3;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    chk(!rf_we, "R9 no write", rf_we, 0);
    @(negedge clk);
    chk(rf[3] == exp_reg[3], "R9 register untouched", rf[3], exp_reg[3]);
    chk(sb.size() == 0, "R9 one result only", sb.size(), 0);

    // R10: back-to-back stepping on one register
    sb.push_back({1'b0, 12'h600});
    sb.push_back({1'b0, 12'h601});
    exp_reg[6] = 12'h602;
    start = 1'b1; mode = 3'd4; reg_sel = 3'd6;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(rf[6] == 12'h602, "R10 forwarded pointer", rf[6], 12'h602);
    chk(sb.size() == 0, "R10 both results", sb.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule